// File: doc/BRIEF.md
# Machine Timer with Compare Interrupt

This block keeps a 64-bit free-running machine timer beside a 64-bit compare value and raises a timer interrupt whenever the count has caught up with the compare value. Software reaches the timer through a small register window. Each 64-bit quantity is split into a low half and a high half of 32 bits, and a separate control word sets the counting mode.

The timer advances on every clock in full-speed mode. In ticked mode it advances only in cycles where an external tick pulse is high. Two debug-halt inputs, one per core, can each freeze the count. Each of them has its own enable bit in the control word, and both enables are on after reset. The compare value resets to all ones, so no interrupt is raised out of reset. Tick generation and debug logic lie outside the block and arrive as plain input signals.

Top module: `mtimer_top`

## Requirements
- R1: While `rst` is high at a clock edge, the timer is set to 0, both compare halves to 0xFFFFFFFF and the control word to 0xD, and `irq` is 0.
- R2: The control word sits at address 0. Bit 0 is the run enable, bit 1 selects full speed, bit 2 enables the pause on `halt_core0` and bit 3 enables the pause on `halt_core1`. Bits 31:4 ignore writes and read as zero.
- R3: With the run enable set, full speed selected and no pause active, the timer rises by exactly one at every clock edge.
- R4: With full speed cleared, the timer rises by one only at edges where `tick` is high, and it holds at all other edges.
- R5: With the run enable cleared, the timer holds its value, and it can still be written.
- R6: At an edge where a halt input is high and its pause enable bit is set, the timer holds. A halt input whose pause enable bit is clear has no effect on counting.
- R7: An increment that carries out of the low half adds one to the high half at the same edge.
- R8: Writing address 1 replaces the timer's low half and writing address 2 replaces its high half. The other half keeps its value, no increment happens at that edge, and the written value reads back at the next cycle.
- R9: Addresses 3 and 4 hold the compare low and high halves. They are written and read back whole. Reads of addresses 5 to 7 return zero.
- R10: `irq` is 1 exactly when the 64-bit timer value, taken as unsigned, is greater than or equal to the 64-bit compare value. It follows register state with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register window |
| reg_addr | input | 3 | Register select for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| tick | input | 1 | Count pulse used in ticked mode |
| halt_core0 | input | 1 | Core 0 is in debug halt |
| halt_core1 | input | 1 | Core 1 is in debug halt |
| irq | output | 1 | Timer interrupt, count >= compare |

## Verification
Every register write takes effect at the single clock edge that samples the strobe. The new value is therefore visible on `reg_rdata` at the next falling edge. Because `irq` and `reg_rdata` are combinational from registers, the interrupt reflects a write within that same half cycle. A count moves once per enabled edge, so after N clock edges the expected value is the start value plus the number of those edges that qualified. The bench drives inputs at falling edges, holds each for exactly one rising edge, and samples the outputs at the following falling edge. This way every expected value is counted edge by edge.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

    localparam int HALF_W_DEF = 32;
    localparam int ADDR_W     = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL   = 3'd0,
        SEL_CNT_LO = 3'd1,
        SEL_CNT_HI = 3'd2,
        SEL_CMP_LO = 3'd3,
        SEL_CMP_HI = 3'd4
    } reg_sel_e;

    // control word, LSB = run enable
    typedef struct packed {
        logic hold_on_halt1;
        logic hold_on_halt0;
        logic every_clk;
        logic run;
    } tmr_ctrl_t;

    localparam int CTRL_W = $bits(tmr_ctrl_t);

    localparam tmr_ctrl_t CTRL_RESET = '{
        hold_on_halt1: 1'b1,
        hold_on_halt0: 1'b1,
        every_clk:     1'b0,
        run:           1'b1
    };

    typedef struct packed {
        logic ctrl;
        logic cnt_lo;
        logic cnt_hi;
        logic cmp_lo;
        logic cmp_hi;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_wr(input logic wr, input logic [ADDR_W-1:0] a);
        wr_strobe_t s;
        s.ctrl   = wr && (a == SEL_CTRL);
        s.cnt_lo = wr && (a == SEL_CNT_LO);
        s.cnt_hi = wr && (a == SEL_CNT_HI);
        s.cmp_lo = wr && (a == SEL_CMP_LO);
        s.cmp_hi = wr && (a == SEL_CMP_HI);
        return s;
    endfunction

endpackage

// File: rtl/mtimer_ctrl.sv
module mtimer_ctrl
    import mtimer_pkg::*;
#(
    parameter int HALF_W = HALF_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [HALF_W-1:0] wdata,
    input  logic              tick,
    input  logic [1:0]        halt,
    output tmr_ctrl_t         ctrl,
    output logic              step
);
    localparam int NUM_HALT = 2;

    tmr_ctrl_t       ctrl_q;
    logic [NUM_HALT-1:0] hold_en;
    logic [NUM_HALT-1:0] hold_hit;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= CTRL_RESET;
        else if (wr)
            ctrl_q <= tmr_ctrl_t'(wdata[CTRL_W-1:0]);
    end

    assign hold_en = {ctrl_q.hold_on_halt1, ctrl_q.hold_on_halt0};

    for (genvar g = 0; g < NUM_HALT; g++) begin : g_hold
        assign hold_hit[g] = halt[g] & hold_en[g];
    end

    assign step = ctrl_q.run && (hold_hit == '0) && (ctrl_q.every_clk || tick);
    assign ctrl = ctrl_q;

endmodule

// File: rtl/mtimer_count.sv
module mtimer_count #(
    parameter int HALF_W = 32,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wdata,
    output logic [CNT_W-1:0]  count
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) cnt_q[HALF_W-1:0]     <= wdata;
            if (wr_hi) cnt_q[CNT_W-1:HALF_W] <= wdata;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/mtimer_cmp.sv
module mtimer_cmp #(
    parameter int HALF_W = 32,
    localparam int CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  cmp,
    output logic              irq
);
    logic [CNT_W-1:0] cmp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '1;
        end else begin
            if (wr_lo) cmp_q[HALF_W-1:0]     <= wdata;
            if (wr_hi) cmp_q[CNT_W-1:HALF_W] <= wdata;
        end
    end

    assign cmp = cmp_q;
    assign irq = (count >= cmp_q);

endmodule

// File: rtl/mtimer_top.sv
module mtimer_top
    import mtimer_pkg::*;
#(
    parameter int HALF_W = HALF_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [HALF_W-1:0] reg_wdata,
    output logic [HALF_W-1:0] reg_rdata,
    input  logic              tick,
    input  logic              halt_core0,
    input  logic              halt_core1,
    output logic              irq
);
    localparam int CNT_W = 2 * HALF_W;

    wr_strobe_t       stb;
    tmr_ctrl_t        ctrl_q;
    logic             step;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] cmp_q;

    assign stb = decode_wr(reg_wr, reg_addr);

    mtimer_ctrl #(.HALF_W(HALF_W)) ctrl_i (
        .clk   (clk),
        .rst   (rst),
        .wr    (stb.ctrl),
        .wdata (reg_wdata),
        .tick  (tick),
        .halt  ({halt_core1, halt_core0}),
        .ctrl  (ctrl_q),
        .step  (step)
    );

    mtimer_count #(.HALF_W(HALF_W)) count_i (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .wr_lo (stb.cnt_lo),
        .wr_hi (stb.cnt_hi),
        .wdata (reg_wdata),
        .count (count_q)
    );

    mtimer_cmp #(.HALF_W(HALF_W)) cmp_i (
        .clk   (clk),
        .rst   (rst),
        .wr_lo (stb.cmp_lo),
        .wr_hi (stb.cmp_hi),
        .wdata (reg_wdata),
        .count (count_q),
        .cmp   (cmp_q),
        .irq   (irq)
    );

    always_comb begin
        unique case (reg_addr)
            SEL_CTRL:   reg_rdata = {{(HALF_W-CTRL_W){1'b0}}, ctrl_q};
            SEL_CNT_LO: reg_rdata = count_q[HALF_W-1:0];
            SEL_CNT_HI: reg_rdata = count_q[CNT_W-1:HALF_W];
            SEL_CMP_LO: reg_rdata = cmp_q[HALF_W-1:0];
            SEL_CMP_HI: reg_rdata = cmp_q[CNT_W-1:HALF_W];
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mtimer_chk.sv
module mtimer_chk #(
    parameter int HALF_W = 32,
    localparam int CNT_W = 2 * HALF_W
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [HALF_W-1:0] reg_wdata,
    input logic [HALF_W-1:0] reg_rdata,
    input logic              tick,
    input logic              halt_core0,
    input logic              halt_core1,
    input logic              irq,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  cmp,
    input logic [3:0]        ctrl_bits
);
    logic cnt_wr;
    assign cnt_wr = reg_wr && (reg_addr == 3'd1 || reg_addr == 3'd2);

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (count == '0 && cmp == '1 && ctrl_bits == 4'hD && !irq));

    a_r2_ctrl_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 3'd0) |-> (reg_rdata[HALF_W-1:4] == '0));

    a_r3_fullspeed_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ctrl_bits[0]) && $past(ctrl_bits[1])
         && !$past(halt_core0 && ctrl_bits[2]) && !$past(halt_core1 && ctrl_bits[3])
         && !$past(cnt_wr))
        |-> (count == $past(count) + 1'b1));

    a_r4_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ctrl_bits[1]) && !$past(tick) && !$past(cnt_wr))
        |-> $stable(count));

    a_r5_hold_disabled: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ctrl_bits[0]) && !$past(cnt_wr)) |-> $stable(count));

    a_r6_hold_paused: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(halt_core0 && ctrl_bits[2]) && !$past(cnt_wr))
        |-> $stable(count));

    a_r8_write_lo: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(reg_wr && reg_addr == 3'd1))
        |-> (count[HALF_W-1:0] == $past(reg_wdata)
             && count[CNT_W-1:HALF_W] == $past(count[CNT_W-1:HALF_W])));

    a_r10_irq_on_equal: assert property (@(posedge clk) disable iff (rst)
        (count == cmp) |-> irq);

endmodule

bind mtimer_top mtimer_chk #(.HALF_W(HALF_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .tick       (tick),
    .halt_core0 (halt_core0),
    .halt_core1 (halt_core1),
    .irq        (irq),
    .count      (count_q),
    .cmp        (cmp_q),
    .ctrl_bits  (ctrl_q)
);

// File: tb/mtimer_top_tb_top.sv
module mtimer_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tick = 1'b0;
    logic        halt_core0 = 1'b0;
    logic        halt_core1 = 1'b0;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mtimer_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .tick       (tick),
        .halt_core0 (halt_core0),
        .halt_core1 (halt_core1),
        .irq        (irq)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, hold across exactly one rising edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        logic [31:0] v, v2, lo, hi;
        logic [15:0] pat;
        int ones;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v); check("R1 ctrl", v, 32'hD);
        rd(3'd1, v); check("R1 cnt lo", v, 0);
        rd(3'd2, v); check("R1 cnt hi", v, 0);
        rd(3'd3, v); check("R1 cmp lo", v, 32'hFFFF_FFFF);
        rd(3'd4, v); check("R1 cmp hi", v, 32'hFFFF_FFFF);
        check("R1 irq", irq, 0);
        rd(3'd6, v); check("R9 unused addr", v, 0);

        // R4 ticked mode: no ticks, then a tick pattern
        idle(5);
        rd(3'd1, v); check("R4 no tick hold", v, 0);
        pat = 16'b1011_0010_1110_0101;
        ones = 0;
        for (int i = 0; i < 16; i++) begin
            tick = pat[i];
            if (pat[i]) ones++;
            @(negedge clk);
        end
        tick = 1'b0;
        rd(3'd1, v); check("R4 tick count", v, ones);

        // R3 full speed, R8 write suppresses increment
        wr(3'd0, 32'h3);
        wr(3'd1, 32'd100);
        rd(3'd1, v); check("R8 lo write no inc", v, 100);
        idle(10);
        rd(3'd1, v); check("R3 full speed", v, 110);

        // R7 carry, R8 half writes
        wr(3'd2, 32'd5);
        wr(3'd1, 32'hFFFF_FFFD);
        rd(3'd2, hi); check("R8 hi write", hi, 5);
        idle(3);
        rd(3'd1, lo); rd(3'd2, hi);
        check("R7 carry", {hi, lo}, {32'd6, 32'd0});

        // R5 disabled holds, still writable
        wr(3'd0, 32'h2);
        rd(3'd1, v);
        idle(5);
        rd(3'd1, v2); check("R5 hold", v2, v);
        wr(3'd1, 32'd7);
        rd(3'd1, v); check("R5 write while off", v, 7);

        // R6 pause enables
        wr(3'd0, 32'h7);
        halt_core0 = 1'b1;
        idle(5);
        rd(3'd1, v); check("R6 halt0 pauses", v, 7);
        halt_core0 = 1'b0; halt_core1 = 1'b1;
        idle(5);
        rd(3'd1, v); check("R6 halt1 ignored", v, 12);
        wr(3'd0, 32'hB);
        idle(4);
        rd(3'd1, v); check("R6 halt1 pauses", v, 13);
        halt_core1 = 1'b0;

        // R2 upper control bits
        wr(3'd0, 32'hFFFF_FFF1);
        rd(3'd0, v); check("R2 upper bits zero", v, 32'h1);

        // R10 / R9 compare sweep with timer frozen
        wr(3'd0, 32'h0);
        wr(3'd2, 32'd0);
        for (int h = 0; h < 2; h++) begin
            for (int l = 0; l < 8; l++) begin
                for (int c = 0; c < 8; c++) begin
                    wr(3'd4, h);
                    wr(3'd3, l);
                    wr(3'd1, c);
                    #1;
                    check("R10 irq sweep", irq,
                          ({32'd0, 32'(c)} >= {32'(h), 32'(l)}) ? 1 : 0);
                end
            end
        end
        rd(3'd3, v); check("R9 cmp lo", v, 7);
        rd(3'd4, v); check("R9 cmp hi", v, 1);

        // R10 unsigned across halves
        wr(3'd4, 32'd0); wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd2, 32'd1); wr(3'd1, 32'd0);
        #1; check("R10 hi beats lo", irq, 1);
        wr(3'd4, 32'd1); wr(3'd3, 32'd0);
        wr(3'd2, 32'd0); wr(3'd1, 32'hFFFF_FFFF);
        #1; check("R10 below by one", irq, 0);
        wr(3'd4, 32'h8000_0000); wr(3'd3, 32'd0);
        wr(3'd2, 32'h7FFF_FFFF);
        #1; check("R10 unsigned msb", irq, 0);

        // R10 rises as the count reaches compare at full speed
        wr(3'd2, 32'd0); wr(3'd1, 32'd0);
        wr(3'd4, 32'd0); wr(3'd3, 32'd3);
        wr(3'd0, 32'h3);
        idle(2);
        #1; check("R10 before match", irq, 0);
        idle(1);
        #1; check("R10 at match", irq, 1);

        finish_run();
    end

endmodule